// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Port

This block is a bank of general-purpose pins controlled through a plain word-wide register bus. Each pin can be an input or an output, and each output can either drive both levels or work as an open-drain driver. Pad inputs are brought into the clock domain by a synchroniser. Every pin has an edge detector that records transitions in a sticky status register. Software clears that register by writing ones. A per-pin mask selects which recorded events reach the single interrupt line.

Pins are numbered from the most significant bit down, so pin n occupies register bit NPINS-1-n in every register. The pad vectors are indexed by pin number. A sense register selects, per pin, whether only falling edges are recorded or whether both directions are. Reading the data register returns the written value for output pins and the synchronised pad level for input pins. A read-modify-write of that register therefore leaves the output pins intact.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every pin is an input, every pad_oe bit is 0, irq is 0, and the direction, open-drain, data, status, mask and sense registers all read 0.
- R2: Byte offsets decode as follows: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event status, 0x10 event mask, 0x14 edge sense. The direction, open-drain, mask and sense registers read back the value written. Any other offset reads 0, and a write to it changes no register.
- R3: Pin n corresponds to register bit NPINS-1-n in every register. pad_in[n], pad_out[n] and pad_oe[n] belong to pin n.
- R4: A direction bit of 1 makes the pin an output, with pad_oe=1 and pad_out equal to its data bit when open-drain is off. A direction bit of 0 gives pad_oe=0.
- R5: On an output pin whose open-drain bit is 1, a data bit of 0 gives pad_oe=1 and pad_out=0, and a data bit of 1 gives pad_oe=0. pad_out is never 1 on an open-drain pin.
- R6: A read of the data register returns the last written data bit for output pins. For input pins it returns the pad level, which becomes visible after the second rising clock edge following the pad change and not after the first.
- R7: With its sense bit at 0, a pin records both rising and falling pad transitions in its status bit, whatever its direction. The status bit becomes 1 after the third rising clock edge following the pad change and is still 0 after the second.
- R8: With its sense bit at 1, a pin records only falling transitions. A rising transition leaves its status bit at 0.
- R9: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every pending event.
- R10: When a new edge and a clearing write reach the same status bit in the same cycle, the bit ends up set. Other bits cleared by that write still clear.
- R11: irq is 1 exactly when some status bit is 1 and its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, combinational from bus_addr |
| pad_in | input | NPINS | Pad levels, indexed by pin |
| pad_out | output | NPINS | Pad drive values, indexed by pin |
| pad_oe | output | NPINS | Pad drive enables, indexed by pin |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle the checker confirms several properties. An open-drain pin never drives high, and an input pin never drives at all. A status bit rises only after a qualifying synchronised edge, and never after a rising edge on a falling-only pin. It falls only under a write of one, and a fresh edge always leaves it set. The checker also requires that irq never asserts with an empty mask. Only the bench scenarios show the exact capture and read latencies, the MSB-first mapping for each individual pin, the register decode, and the mixed read of the data register.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_DIR = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_ODR = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_DAT = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_STS = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_MSK = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_SNS = ADDR_W'('h14);

  logic [NPINS-1:0] dir_q, odr_q, dat_q, evt_q, msk_q, sns_q;
  logic [NPINS-1:0] s1_q, s2_q, s3_q;
  logic [NPINS-1:0] pin_lvl, hit, clr;

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    localparam int B = NPINS - 1 - n;
    assign pin_lvl[B] = pad_in[n];
    assign pad_oe[n]  = dir_q[B] & ~(odr_q[B] & dat_q[B]);
    assign pad_out[n] = dat_q[B] & ~odr_q[B];
  end

  assign hit = (s2_q ^ s3_q) & ~(sns_q & s2_q);
  assign clr = (bus_we && bus_addr == OFS_STS) ? bus_wdata : '0;
  assign irq = |(evt_q & msk_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0; odr_q <= '0; dat_q <= '0;
      evt_q <= '0; msk_q <= '0; sns_q <= '0;
      s1_q  <= '0; s2_q  <= '0; s3_q  <= '0;
    end else begin
      s1_q  <= pin_lvl;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      evt_q <= (evt_q & ~clr) | hit;
      if (bus_we) begin
        case (bus_addr)
          OFS_DIR: dir_q <= bus_wdata;
          OFS_ODR: odr_q <= bus_wdata;
          OFS_DAT: dat_q <= bus_wdata;
          OFS_MSK: msk_q <= bus_wdata;
          OFS_SNS: sns_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_DIR: bus_rdata = dir_q;
      OFS_ODR: bus_rdata = odr_q;
      OFS_DAT: bus_rdata = (dat_q & dir_q) | (s2_q & ~dir_q);
      OFS_STS: bus_rdata = evt_q;
      OFS_MSK: bus_rdata = msk_q;
      OFS_SNS: bus_rdata = sns_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic              irq,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  odr_q,
  input logic [NPINS-1:0]  evt_q,
  input logic [NPINS-1:0]  msk_q,
  input logic [NPINS-1:0]  sns_q,
  input logic [NPINS-1:0]  s2_q,
  input logic [NPINS-1:0]  s3_q
);
  logic [NPINS-1:0] od_pin, dir_pin, clr_req, qual;

  always_comb begin
    for (int n = 0; n < NPINS; n++) begin
      od_pin[n]  = odr_q[NPINS-1-n];
      dir_pin[n] = dir_q[NPINS-1-n];
    end
    clr_req = (bus_we && bus_addr == ADDR_W'('h0C)) ? bus_wdata : '0;
    qual    = sns_q ? (s3_q & ~s2_q) : (s2_q ^ s3_q);
    for (int b = 0; b < NPINS; b++)
      qual[b] = sns_q[b] ? (s3_q[b] & ~s2_q[b]) : (s2_q[b] ^ s3_q[b]);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && !irq));

  assert_input_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_pin) == '0);

  assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & od_pin) == '0);

  assert_event_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~$past(evt_q) & ~$past(s2_q ^ s3_q)) == '0);

  assert_no_rising_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~$past(evt_q) & $past(sns_q & s2_q & ~s3_q)) == '0);

  assert_clear_needs_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_q) & ~evt_q & ~$past(clr_req)) == '0);

  assert_edge_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(qual) & ~evt_q) == '0);

  assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msk_q != '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .dir_q(dir_q), .odr_q(odr_q), .evt_q(evt_q), .msk_q(msk_q),
  .sns_q(sns_q), .s2_q(s2_q), .s3_q(s3_q)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08,
                         A_STS = 5'h0C, A_MSK = 5'h10, A_SNS = 5'h14, A_BAD = 5'h18;

  logic clk = 0, rst_n = 0, bus_we = 0, irq;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
  int total = 0, failed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[i] = v[31-i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk);
    #1 bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, bit_b, dat, dir, od;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    foreach (v[i]) ;
    rd(A_DIR, v); chk("R1 dir", v, 0);
    rd(A_ODR, v); chk("R1 odr", v, 0);
    rd(A_DAT, v); chk("R1 data", v, 0);
    rd(A_STS, v); chk("R1 status", v, 0);
    rd(A_MSK, v); chk("R1 mask", v, 0);
    rd(A_SNS, v); chk("R1 sense", v, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 register decode and readback
    wr(A_ODR, 32'h1357_9BDF); wr(A_MSK, 32'h2468_ACE0); wr(A_SNS, 32'h0F0F_F0F0);
    wr(A_DIR, 32'hDEAD_BEEF); wr(A_BAD, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(A_DIR, v); chk("R2 dir readback", v, 32'hDEAD_BEEF);
    rd(A_ODR, v); chk("R2 odr readback", v, 32'h1357_9BDF);
    rd(A_MSK, v); chk("R2 mask readback", v, 32'h2468_ACE0);
    rd(A_SNS, v); chk("R2 sense readback", v, 32'h0F0F_F0F0);
    rd(A_BAD, v); chk("R2 unmapped reads 0", v, 0);
    wr(A_DIR, 0); wr(A_ODR, 0); wr(A_MSK, 0); wr(A_SNS, 0);

    // R4 push-pull outputs, R6 output readback, R3 mapping
    dat = 32'hC3A5_0F96;
    wr(A_DIR, 32'hFFFF_FFFF); wr(A_DAT, dat);
    @(negedge clk);
    chk("R4 pad_out", pad_out, rev(dat));
    chk("R4 pad_oe", pad_oe, 32'hFFFF_FFFF);
    rd(A_DAT, v); chk("R6 output readback", v, dat);
    wr(A_DIR, 0);
    @(negedge clk);
    chk("R4 inputs released", pad_oe, 0);

    // R5 open-drain combinations
    dir = 32'hFFFF_FFFF; od = 32'hFFFF_0000; dat = 32'h00FF_00FF;
    wr(A_DIR, dir); wr(A_ODR, od); wr(A_DAT, dat);
    @(negedge clk);
    chk("R5 od oe", pad_oe, rev(~(od & dat)));
    chk("R5 od out", pad_out, rev(dat & ~od));
    wr(A_ODR, 0);

    // R6 mixed direction read
    dir = 32'hF0F0_00FF; dat = 32'h1234_5678;
    wr(A_DIR, dir); wr(A_DAT, dat);
    @(negedge clk); pad_in = 32'hA5A5_5A5A;
    clocks(1); rd(A_DAT, v);
    chk("R6 mixed before sync", v, dat & dir);
    clocks(1); rd(A_DAT, v);
    chk("R6 mixed read", v, (dat & dir) | (rev(32'hA5A5_5A5A) & ~dir));
    wr(A_DIR, 0); pad_in = 0;
    clocks(4);

    // R3 pin-to-bit mapping sweep on inputs
    for (int n = 0; n < 32; n++) begin
      pad_in = 32'h1 << n;
      clocks(2); rd(A_DAT, v);
      chk("R3 input map", v, 32'h8000_0000 >> n);
    end
    pad_in = 0; clocks(4);

    // R7/R8 edge capture sweep, R11 irq per pin
    for (int s = 0; s < 2; s++) begin
      wr(A_SNS, s ? 32'hFFFF_FFFF : 32'h0);
      for (int n = 0; n < 32; n++) begin
        bit_b = 32'h8000_0000 >> n;
        wr(A_STS, 32'hFFFF_FFFF);
        @(negedge clk); pad_in[n] = 1;
        clocks(2); rd(A_STS, v);
        chk(s ? "R8 rise latency" : "R7 rise latency", v, 0);
        clocks(1); rd(A_STS, v);
        chk(s ? "R8 rise ignored" : "R7 rise captured", v, s ? 0 : bit_b);
        wr(A_STS, 32'hFFFF_FFFF);
        @(negedge clk); pad_in[n] = 0;
        clocks(3); rd(A_STS, v);
        chk(s ? "R8 fall captured" : "R7 fall captured", v, bit_b);
        chk("R11 masked off", {31'b0, irq}, 0);
        wr(A_MSK, bit_b);
        @(negedge clk);
        chk("R11 unmasked", {31'b0, irq}, 1);
        wr(A_MSK, ~bit_b);
        @(negedge clk);
        chk("R11 other mask", {31'b0, irq}, 0);
        wr(A_MSK, 0);
      end
    end
    wr(A_SNS, 0);

    // R7 capture on an output pin
    wr(A_STS, 32'hFFFF_FFFF); wr(A_DIR, 32'hFFFF_FFFF);
    @(negedge clk); pad_in[9] = 1;
    clocks(3); rd(A_STS, v); chk("R7 output pin captures", v, 32'h8000_0000 >> 9);
    wr(A_DIR, 0);

    // R9 write-one-to-clear
    wr(A_STS, 32'hFFFF_FFFF);
    @(negedge clk); pad_in[1] = 1; pad_in[4] = 1; pad_in[30] = 1;
    clocks(3);
    rd(A_STS, v); chk("R9 setup", v, 32'h4800_0002);
    wr(A_STS, 0); @(negedge clk);
    rd(A_STS, v); chk("R9 zero keeps", v, 32'h4800_0002);
    wr(A_STS, 32'h0800_0000); @(negedge clk);
    rd(A_STS, v); chk("R9 single clear", v, 32'h4000_0002);
    wr(A_STS, 32'hFFFF_FFFF); @(negedge clk);
    rd(A_STS, v); chk("R9 all clear", v, 0);

    // R10 new edge beats simultaneous clear
    @(negedge clk); pad_in[12] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = A_STS; bus_wdata = 32'hFFFF_FFFF; bus_we = 1;
    @(posedge clk); #1 bus_we = 0;
    @(negedge clk); rd(A_STS, v);
    chk("R10 edge wins", v, 32'h8000_0000 >> 12);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule